// File: doc/BRIEF.md
# Channel Word Transposer

A capture front end delivers its samples channel by channel: every 16-bit word holds sixteen consecutive samples of a single channel, and the words visit the enabled channels in a fixed rotation. This block turns that stream back into time order. It takes the stream one byte at a time, pairs the bytes into words and scatters the bits of each word into sixteen per-time accumulators. The channel bits it sets come from a small programmable table that maps each rotation slot to an output bit pattern. When every enabled channel has contributed its word, the sixteen accumulated samples leave the block, earliest first, each with one bit per channel.

Software loads the slot table and the number of enabled channels before a capture starts. The upstream transfer engine marks the final byte of each transfer. The block keeps its position in the rotation across transfers. A transfer that ends halfway through a word is flagged and its stray byte is dropped. Output samples use a valid/ready handshake. The byte input is held off while a burst of sixteen samples drains.

Top module: `chan_word_transposer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `odd_error` is 0.
- R2: Two accepted bytes form one word. The first byte is bits 7:0 and the second byte is bits 15:8.
- R3: Bit 15 of a word is the earliest of its sixteen samples and bit 0 is the latest. For every set bit, the mask of the current slot is ORed into output sample 15-b, where b is the bit position and output sample 0 is the earliest.
- R4: The slot index starts at 0 and advances by one per word. After the word for slot count-1 it returns to 0, and in the next cycle the block presents the sixteen accumulated samples, earliest first. The accumulators are all zero after the sixteenth handshake.
- R5: When `in_last` comes with the first byte of a word, `odd_error` is 1 in the following cycle only. The byte is dropped, and the next byte accepted is again the low byte of a word.
- R6: `in_last` on the second byte of a word leaves the slot index and the accumulators as they are, so one rotation may span two transfers.
- R7: Writes to the slot table or to the channel count take effect only when the block is idle: slot index 0, no byte held and no burst in progress. A count write of 0 or above 16 is ignored even when the block is idle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_sample` does not change. `in_ready` is 0 whenever `out_valid` is 1.
- R9: After reset the channel count is 16 and slot table entry i holds the one-hot mask with only bit i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask_we | input | 1 | Write strobe for one slot table entry |
| cfg_slot | input | 4 | Slot table entry to write |
| cfg_mask | input | 16 | Channel bit mask for that slot |
| cfg_count_we | input | 1 | Write strobe for the channel count |
| cfg_count | input | 5 | Number of enabled channels, 1 to 16 |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Byte input can accept |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its transfer |
| out_valid | output | 1 | `out_sample` holds a sample |
| out_ready | input | 1 | Downstream takes the sample |
| out_sample | output | 16 | Time-ordered sample, one bit per channel |
| odd_error | output | 1 | One-cycle flag: transfer ended with a dangling byte |

## Verification
The bench targets the rotation boundary. If the wrap came one word early or late, the burst would start at the wrong word, and the diagonal pattern under the default table would land on the wrong samples. It also targets bit and byte order: a swapped byte pair or a reversed bit order moves set bits to mirrored or shifted sample positions. A dangling byte is driven next to a real word, so a design that kept the byte would shift every later word by one byte. Writes to the table and count are tried in the middle of a rotation, and count values of 0 and 17 are tried at idle. A design that took any of them would change the rotation length or the masks, and the outputs would show it.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

   localparam int CWT_DEF_CHANNELS = 16;
   localparam int CWT_DEF_BYTE_W   = 8;

   typedef enum logic {
      EMIT_IDLE = 1'b0,
      EMIT_RUN  = 1'b1
   } emit_e;

endpackage

// File: rtl/cwt_byte_pair.sv
module cwt_byte_pair #(
   parameter int BYTE_W    = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int WORD_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [BYTE_W-1:0] byte_d,
   input  logic              byte_last,
   output logic              word_v,
   output logic [WORD_W-1:0] word_d,
   output logic              half_held,
   output logic              odd_err
);

   logic [BYTE_W-1:0] first_q;
   logic              have_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         have_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= take && byte_last && !have_q;
         if (take) begin
            if (!have_q) begin
               first_q <= byte_d;
               have_q  <= !byte_last;
            end else begin
               have_q  <= 1'b0;
            end
         end
      end
   end

   assign word_v    = take && have_q;
   assign half_held = have_q;
   assign odd_err   = err_q;

   if (LOW_FIRST) begin : g_low_first
      assign word_d = {byte_d, first_q};
   end else begin : g_high_first
      assign word_d = {first_q, byte_d};
   end

   // a flagged dangling byte must not be held as half a word
   assert_odd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      odd_err |-> !have_q);

   // the flag lasts one cycle unless another dangling byte follows
   assert_odd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      odd_err |-> $past(take && byte_last));

endmodule

// File: rtl/cwt_slot_table.sv
module cwt_slot_table #(
   parameter int CH       = 16,
   localparam int SLOT_W  = $clog2(CH),
   localparam int CNT_W   = $clog2(CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_open,
   input  logic              cfg_mask_we,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [CH-1:0]     cfg_mask,
   input  logic              cfg_count_we,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [CH-1:0]     rd_mask,
   output logic [CNT_W-1:0]  count
);

   logic [CH-1:0]    ent_w [CH];
   logic [CH*CH-1:0] tab_flat;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_ok;

   for (genvar g = 0; g < CH; g++) begin : g_entry
      localparam logic [CH-1:0] RST_VAL = CH'(1) << g;
      logic [CH-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= RST_VAL;
         end else if (cfg_open && cfg_mask_we && (cfg_slot == SLOT_W'(g))) begin
            val_q <= cfg_mask;
         end
      end
      assign ent_w[g]                 = val_q;
      assign tab_flat[g*CH +: CH]     = val_q;
   end

   assign cnt_ok = (cfg_count != '0) && (cfg_count <= CNT_W'(CH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(CH);
      end else if (cfg_open && cfg_count_we && cnt_ok) begin
         cnt_q <= cfg_count;
      end
   end

   assign rd_mask = ent_w[rd_slot];
   assign count   = cnt_q;

   // table and count frozen outside idle
   assert_cfg_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(tab_flat) && $stable(cnt_q));

   // count stays within 1..CH
   assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) && (cnt_q <= CNT_W'(CH)));

endmodule

// File: rtl/cwt_slot_ctr.sv
module cwt_slot_ctr #(
   parameter int CH       = 16,
   localparam int SLOT_W  = $clog2(CH),
   localparam int CNT_W   = $clog2(CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_v,
   input  logic [CNT_W-1:0]  count,
   output logic [SLOT_W-1:0] slot,
   output logic              wrap
);

   logic [SLOT_W-1:0] slot_q;
   logic              at_end;

   assign at_end = (CNT_W'(slot_q) + CNT_W'(1)) == count;
   assign wrap   = word_v && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (word_v) begin
         slot_q <= at_end ? '0 : slot_q + SLOT_W'(1);
      end
   end

   assign slot = slot_q;

   // slot index never reaches the enabled count
   assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(slot_q) < count);

endmodule

// File: rtl/cwt_lane_accum.sv
module cwt_lane_accum
   import cwt_pkg::*;
#(
   parameter int CH       = 16,
   parameter int WORD_W   = 16,
   localparam int IDX_W   = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_v,
   input  logic [WORD_W-1:0] word_d,
   input  logic [CH-1:0]     mask,
   input  logic              wrap,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [CH-1:0]     out_sample,
   output logic              busy
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   emit_e            st_q;
   logic [IDX_W-1:0] idx_q;
   logic             done;
   logic [CH-1:0]    lane_w [WORD_W];
   logic [WORD_W*CH-1:0] acc_flat;

   assign done = (st_q == EMIT_RUN) && out_ready && (idx_q == LAST_IDX);

   // lane t is the t-th sample in time; word bit WORD_W-1-t feeds it
   for (genvar t = 0; t < WORD_W; t++) begin : g_lane
      logic [CH-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
         end else if (done) begin
            acc_q <= '0;
         end else if (word_v && word_d[WORD_W-1-t]) begin
            acc_q <= acc_q | mask;
         end
      end
      assign lane_w[t]               = acc_q;
      assign acc_flat[t*CH +: CH]    = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= EMIT_IDLE;
         idx_q <= '0;
      end else begin
         case (st_q)
            EMIT_IDLE: begin
               if (wrap) begin
                  st_q  <= EMIT_RUN;
                  idx_q <= '0;
               end
            end
            EMIT_RUN: begin
               if (out_ready) begin
                  if (idx_q == LAST_IDX) begin
                     st_q  <= EMIT_IDLE;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: st_q <= EMIT_IDLE;
         endcase
      end
   end

   assign out_valid  = (st_q == EMIT_RUN);
   assign out_sample = lane_w[idx_q];
   assign busy       = (st_q == EMIT_RUN);

   // stalled sample is held
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sample));

   // a burst ends only after its last sample
   assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(idx_q) == LAST_IDX);

   // accumulators are empty once a burst has gone
   assert_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> acc_flat == '0);

   // no word arrives while a burst drains
   assert_no_word_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !word_v);

endmodule

// File: rtl/chan_word_transposer.sv
module chan_word_transposer #(
   parameter int CH        = cwt_pkg::CWT_DEF_CHANNELS,
   parameter int BYTE_W    = cwt_pkg::CWT_DEF_BYTE_W,
   parameter bit LOW_FIRST = 1'b1,
   localparam int WORD_W   = 2 * BYTE_W,
   localparam int SLOT_W   = $clog2(CH),
   localparam int CNT_W    = $clog2(CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mask_we,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [CH-1:0]     cfg_mask,
   input  logic              cfg_count_we,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CH-1:0]     out_sample,
   output logic              odd_error
);

   if (CH < 2) begin : g_bad_ch
      $error("chan_word_transposer: CH must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("chan_word_transposer: BYTE_W must be at least 1");
   end

   logic              take;
   logic              word_v;
   logic [WORD_W-1:0] word_d;
   logic              half_held;
   logic              emit_busy;
   logic              cfg_open;
   logic [SLOT_W-1:0] slot;
   logic              wrap;
   logic [CH-1:0]     cur_mask;
   logic [CNT_W-1:0]  count;

   assign in_ready = !emit_busy;
   assign take     = in_valid && in_ready;
   assign cfg_open = !emit_busy && (slot == '0) && !half_held;

   cwt_byte_pair #(
      .BYTE_W    (BYTE_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .byte_d    (in_data),
      .byte_last (in_last),
      .word_v    (word_v),
      .word_d    (word_d),
      .half_held (half_held),
      .odd_err   (odd_error)
   );

   cwt_slot_table #(
      .CH (CH)
   ) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_open     (cfg_open),
      .cfg_mask_we  (cfg_mask_we),
      .cfg_slot     (cfg_slot),
      .cfg_mask     (cfg_mask),
      .cfg_count_we (cfg_count_we),
      .cfg_count    (cfg_count),
      .rd_slot      (slot),
      .rd_mask      (cur_mask),
      .count        (count)
   );

   cwt_slot_ctr #(
      .CH (CH)
   ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .word_v (word_v),
      .count  (count),
      .slot   (slot),
      .wrap   (wrap)
   );

   cwt_lane_accum #(
      .CH     (CH),
      .WORD_W (WORD_W)
   ) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_v     (word_v),
      .word_d     (word_d),
      .mask       (cur_mask),
      .wrap       (wrap),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .out_sample (out_sample),
      .busy       (emit_busy)
   );

   // input held off for the whole burst
   assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // a burst starts only from a completed rotation
   assert_burst_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(word_v) && (slot == '0));

endmodule

// File: tb/chan_word_transposer_tb.sv
module chan_word_transposer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mask_we = 1'b0;
   logic [3:0]  cfg_slot = '0;
   logic [15:0] cfg_mask = '0;
   logic        cfg_count_we = 1'b0;
   logic [4:0]  cfg_count = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_sample;
   logic        odd_error;

   always #4 clk = ~clk;

   chan_word_transposer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_mask_we  (cfg_mask_we),
      .cfg_slot     (cfg_slot),
      .cfg_mask     (cfg_mask),
      .cfg_count_we (cfg_count_we),
      .cfg_count    (cfg_count),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .in_last      (in_last),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_sample   (out_sample),
      .odd_error    (odd_error)
   );

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int        m_mask [16];
   int        m_cnt;
   int        m_slot;
   bit        m_phase;
   int        m_low;
   int        m_acc [16];
   bit        m_err;
   int        mq [$];
   int        got [$];
   int        cur_out;
   bit        last_take;
   bit        rdy_rand = 1'b0;

   task automatic fail(string tag, int act, int exp);
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
   endtask

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) fail(tag, act, exp);
   endtask

   task automatic compare();
      chk(out_valid === (mq.size() != 0), "R8 out_valid", int'(out_valid), int'(mq.size() != 0));
      if (mq.size() != 0)
         chk(out_sample === 16'(mq[0]), "R4 out_sample", int'(out_sample), mq[0]);
      chk(in_ready === (mq.size() == 0), "R8 in_ready", int'(in_ready), int'(mq.size() == 0));
      chk(odd_error === m_err, "R5 odd_error", int'(odd_error), int'(m_err));
      cur_out = int'(out_sample);
   endtask

   task automatic tick();
      bit take, hs, open, nerr;
      int w;
      if (rdy_rand) out_ready = 1'($urandom_range(0, 1));
      take = in_valid && (mq.size() == 0);
      hs   = (mq.size() != 0) && out_ready;
      open = (mq.size() == 0) && (m_slot == 0) && !m_phase;
      if (hs) begin
         got.push_back(cur_out);
         void'(mq.pop_front());
      end
      nerr = 1'b0;
      if (take) begin
         if (!m_phase) begin
            if (in_last) nerr = 1'b1;
            else begin
               m_phase = 1'b1;
               m_low   = int'(in_data);
            end
         end else begin
            w = (int'(in_data) << 8) | m_low;
            m_phase = 1'b0;
            for (int i = 0; i < 16; i++)
               if (((w >> (15 - i)) & 1) != 0) m_acc[i] |= m_mask[m_slot];
            m_slot++;
            if (m_slot == m_cnt) begin
               m_slot = 0;
               for (int i = 0; i < 16; i++) begin
                  mq.push_back(m_acc[i]);
                  m_acc[i] = 0;
               end
            end
         end
      end
      m_err = nerr;
      if (open) begin
         if (cfg_mask_we) m_mask[cfg_slot] = int'(cfg_mask);
         if (cfg_count_we && cfg_count >= 1 && cfg_count <= 16) m_cnt = int'(cfg_count);
      end
      last_take = take;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic send_byte(logic [7:0] b, bit last);
      in_valid = 1'b1;
      in_data  = b;
      in_last  = last;
      do tick(); while (!last_take);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic send_word(logic [15:0] w, bit last);
      send_byte(w[7:0], 1'b0);
      send_byte(w[15:8], last);
   endtask

   task automatic drain();
      while (mq.size() != 0) tick();
   endtask

   task automatic cfg_write(bit mwe, int slot, int mask, bit cwe, int cnt);
      cfg_mask_we  = mwe;
      cfg_slot     = 4'(slot);
      cfg_mask     = 16'(mask);
      cfg_count_we = cwe;
      cfg_count    = 5'(cnt);
      tick();
      cfg_mask_we  = 1'b0;
      cfg_count_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
   end

   initial begin
      int first;
      for (int i = 0; i < 16; i++) begin
         m_mask[i] = 1 << i;
         m_acc[i]  = 0;
      end
      m_cnt = 16; m_slot = 0; m_phase = 0; m_low = 0; m_err = 0; cur_out = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
      chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
      chk(odd_error === 1'b0, "R1 odd_error", int'(odd_error), 0);
      compare();

      // R9 default table and count: diagonal pattern over 16 slots
      got.delete();
      for (int s = 0; s < 16; s++) begin
         send_word(16'(1 << (15 - s)), 1'b0);
         if (s == 14) chk(out_valid === 1'b0, "R9 no burst before 16 words", int'(out_valid), 0);
      end
      chk(out_valid === 1'b1, "R9 burst after 16 words", int'(out_valid), 1);
      drain();
      chk(got.size() == 16, "R4 burst length", got.size(), 16);
      for (int i = 0; i < 16 && i < got.size(); i++)
         chk(got[i] == (1 << i), "R9 diagonal sample", got[i], 1 << i);

      // R2 R3 byte and bit order with two channels
      cfg_write(1'b1, 0, 16'h0001, 1'b1, 2);
      cfg_write(1'b1, 1, 16'h0002, 1'b0, 0);
      got.delete();
      send_byte(8'h01, 1'b0);
      send_byte(8'h80, 1'b0);
      send_word(16'hFFFF, 1'b0);
      drain();
      chk(got.size() == 16, "R4 burst length two channels", got.size(), 16);
      for (int i = 0; i < 16 && i < got.size(); i++) begin
         first = (i == 0 || i == 15) ? 3 : 2;
         chk(got[i] == first, "R2 R3 sample order", got[i], first);
      end

      // R5 dangling byte dropped
      send_byte(8'hAA, 1'b1);
      chk(odd_error === 1'b1, "R5 flag raised", int'(odd_error), 1);
      tick();
      chk(odd_error === 1'b0, "R5 flag one cycle", int'(odd_error), 0);
      got.delete();
      send_word(16'h8000, 1'b0);
      send_word(16'h0000, 1'b0);
      drain();
      for (int i = 0; i < 16 && i < got.size(); i++) begin
         first = (i == 0) ? 1 : 0;
         chk(got[i] == first, "R5 realigned word", got[i], first);
      end

      // R6 rotation spanning a transfer end
      got.delete();
      send_word(16'h0001, 1'b1);
      chk(odd_error === 1'b0, "R6 even end no flag", int'(odd_error), 0);
      chk(out_valid === 1'b0, "R6 no burst mid rotation", int'(out_valid), 0);
      send_word(16'h0001, 1'b0);
      drain();
      for (int i = 0; i < 16 && i < got.size(); i++) begin
         first = (i == 15) ? 3 : 0;
         chk(got[i] == first, "R6 spanned rotation", got[i], first);
      end

      // R7 writes outside idle are ignored
      got.delete();
      send_word(16'hFFFF, 1'b0);
      cfg_write(1'b1, 1, 16'h8000, 1'b1, 1);
      send_word(16'h0000, 1'b0);
      chk(out_valid === 1'b1, "R7 count kept mid rotation", int'(out_valid), 1);
      // R8 explicit stall
      out_ready = 1'b0;
      first = int'(out_sample);
      in_valid = 1'b1;
      in_data  = 8'h5A;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(int'(out_sample) == first, "R8 sample held", int'(out_sample), first);
         chk(in_ready === 1'b0, "R8 input stalled", int'(in_ready), 0);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      drain();
      for (int i = 0; i < 16 && i < got.size(); i++)
         chk(got[i] == 1, "R7 mask kept mid rotation", got[i], 1);
      cfg_write(1'b0, 0, 0, 1'b1, 0);
      cfg_write(1'b0, 0, 0, 1'b1, 17);
      got.delete();
      send_word(16'h0000, 1'b0);
      chk(out_valid === 1'b0, "R7 bad count ignored", int'(out_valid), 0);
      send_word(16'hFFFF, 1'b0);
      chk(out_valid === 1'b1, "R7 count still two", int'(out_valid), 1);
      drain();
      for (int i = 0; i < 16 && i < got.size(); i++)
         chk(got[i] == 2, "R7 slot one mask unchanged", got[i], 2);

      // mixed traffic against the reference model
      for (int s = 0; s < 16; s++)
         cfg_write(1'b1, s, int'($urandom_range(0, 65535)), 1'b1, int'($urandom_range(1, 6)));
      rdy_rand = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 9) == 0) begin
            cfg_mask_we  = 1'b1;
            cfg_slot     = 4'($urandom_range(0, 15));
            cfg_mask     = 16'($urandom_range(0, 65535));
            cfg_count_we = 1'b1;
            cfg_count    = 5'($urandom_range(0, 20));
         end
         send_byte(8'($urandom_range(0, 255)), $urandom_range(0, 7) == 0);
         cfg_mask_we  = 1'b0;
         cfg_count_we = 1'b0;
      end
      rdy_rand = 1'b0;
      out_ready = 1'b1;
      drain();
      repeat (2) tick();
      finish_run();
   end

endmodule